// File: doc/BRIEF.md
# Strobe-Latched Bytewide Memory Device Model

This block is the device side of a bytewide nonvolatile memory, written as a synthesizable model that samples its pins on a system clock. It owns a byte array and watches an active-low chip select, write strobe and output enable, together with an address and a data bus. Each access begins on a falling edge of the chip select. At that edge the address is captured, and the access is marked as a write or as a read. The block decides when the data bus may be driven and places written bytes into the array.

An access that begins as a read can turn into a write if the write strobe falls later in the same select-low period. Read data appears only once a fixed access interval has passed. Every access must be followed by a select-high precharge interval. The block measures the access interval, the precharge interval and the maximum select-low time as counts of clock cycles. Falling edges that break the precharge rule are rejected. Timing violations are recorded in a sticky error flag with a code, so the block can be used to check a host memory controller.

All pins are plain level signals sampled on the clock. The select, the strobes and the buses carry no handshake and no back-pressure: the host owns the timing, and the block only reports violations. With the default parameters, one clock is 10 ns, so the access and precharge counts of 7 are 70 ns and the select-low limit of 200 is 2000 ns. The address is 10 bits by default; setting it to 15 gives a 32K x 8 array.

Top module: `ce_latched_mem`

## Requirements
- R1: The address is captured only when an accepted select falling edge is sampled. Address changes while the select stays low have no effect on which byte is read or written.
- R2: If the write strobe is low when the select falls, the access is a write. `bus_drive` stays 0 for that whole select-low period, whatever `out_en_n` does. When the select rises, the byte present on `bus_in` during the last low-select cycle is stored at the captured address.
- R3: If the write strobe is high when the select falls, the access begins as a read. `bus_drive` is 0 while `wr_strobe_n` is low. The write commits on whichever rises first, the strobe or the select, using the bus value held while the strobe was low. After a strobe-ended commit, the output shows the new byte.
- R4: In a read access with `out_en_n` low, `bus_drive` is 0 until ACCESS_CYC clock edges after the accepted falling edge, and 1 from then on. `bus_out` carries the stored byte while driving and is 0 otherwise.
- R5: While `out_en_n` or `chip_sel_n` is high, `bus_drive` is 0 within the same cycle.
- R6: An internal access runs for ACCESS_CYC clocks even if the select rises early. A falling edge sampled while it is still running is rejected, `err_kind` becomes 3, and the array is not modified.
- R7: A falling edge that follows fewer than PRECHARGE_CYC select-high clock edges is rejected with `err_kind` 1, and the array is not modified.
- R8: A select held low for more than LOW_MAX_CYC clock edges in an accepted access raises `err_kind` 2, once per access. Exactly LOW_MAX_CYC edges is legal.
- R9: `err_sticky` stays set until `err_clear` is asserted. `err_kind` keeps the code of the first violation after a clear. `err_clear` wins over a violation in the same cycle.
- R10: After reset, `bus_drive`, `bus_out`, `err_sticky` and `err_kind` are 0. The first falling edge is accepted without waiting for a precharge interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel_n | input | 1 | Active-low chip select; each falling edge starts an access |
| wr_strobe_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable |
| addr_in | input | ADDR_W | Byte address, captured at an accepted falling edge |
| bus_in | input | DATA_W | Data presented by the host for writes |
| bus_out | output | DATA_W | Read data; 0 when not driving |
| bus_drive | output | 1 | High when the device drives the data bus |
| err_clear | input | 1 | Clears the error flag and code |
| err_sticky | output | 1 | Set by any timing violation |
| err_kind | output | 2 | First violation code: 1 short precharge, 2 select low too long, 3 access still running |

## Verification
The hardest case to reach is a falling edge that arrives while the previous internal access is still running. This needs a select-low pulse far shorter than the access interval, followed by a very short high gap. Random traffic with legal timing never produces it. The stimulus builds it directly: a one-clock select pulse, a two-clock gap, then a write attempt to a byte whose value is known. The test then checks the error code, and a later legal read confirms the byte is unchanged. The select-low limit is also tested at its exact boundary and one clock past it, with clear held during the violation to show that clear wins.

// File: rtl/celm_pkg.sv
`timescale 1ns/1ps
package celm_pkg;
  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_PRE_SHORT = 2'd1,
    ERR_LOW_LONG  = 2'd2,
    ERR_CYC_BUSY  = 2'd3
  } err_kind_e;
endpackage

// File: rtl/celm_timer.sv
`timescale 1ns/1ps
module celm_timer #(
  parameter int ACCESS_CYC    = 7,
  parameter int PRECHARGE_CYC = 7,
  parameter int LOW_MAX_CYC   = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic accept,
  input  logic sess_active,
  output logic fall_seen,
  output logic pre_done,
  output logic cyc_busy,
  output logic acc_ready,
  output logic low_over
);
  localparam int AW = $clog2(ACCESS_CYC + 1);
  localparam int PW = $clog2(PRECHARGE_CYC + 1);
  localparam int LW = $clog2(LOW_MAX_CYC + 2);
  localparam logic [AW-1:0] ACC_END = AW'(ACCESS_CYC);
  localparam logic [PW-1:0] PC_END  = PW'(PRECHARGE_CYC);
  localparam logic [LW-1:0] LOW_END = LW'(LOW_MAX_CYC);

  logic          sel_q;
  logic          rise_seen;
  logic          live;
  logic [AW-1:0] acc_cnt;
  logic [PW-1:0] pc_cnt;
  logic [LW-1:0] low_cnt;

  assign fall_seen = sel_q & ~sel_n;
  assign rise_seen = ~sel_q & sel_n;
  assign pre_done  = (pc_cnt >= PC_END);
  assign cyc_busy  = live && (acc_cnt < ACC_END);
  assign acc_ready = live && (acc_cnt >= ACC_END);
  assign low_over  = sess_active && !sel_n && (low_cnt == LOW_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b1;
    end else begin
      sel_q <= sel_n;
    end
  end

  // internal access interval: runs to its end whatever the select does
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live    <= 1'b0;
      acc_cnt <= '0;
    end else if (accept) begin
      live    <= 1'b1;
      acc_cnt <= AW'(1);
    end else if (live && (acc_cnt < ACC_END)) begin
      acc_cnt <= acc_cnt + AW'(1);
    end
  end

  // precharge: select-high edges since the last rise, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_cnt <= PC_END;
    end else if (rise_seen) begin
      pc_cnt <= PW'(1);
    end else if (sel_n && (pc_cnt < PC_END)) begin
      pc_cnt <= pc_cnt + PW'(1);
    end
  end

  // select-low duration of an accepted access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (accept) begin
      low_cnt <= LW'(1);
    end else if (sess_active && !sel_n && (low_cnt <= LOW_END)) begin
      low_cnt <= low_cnt + LW'(1);
    end
  end

  assert_low_over_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    low_over |=> !low_over);

  assert_ready_follows_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_ready) |-> $past(cyc_busy || accept));
endmodule

// File: rtl/celm_store.sv
`timescale 1ns/1ps
module celm_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  assign rd_q = cells[rd_addr];
endmodule

// File: rtl/celm_errlog.sv
`timescale 1ns/1ps
module celm_errlog
  import celm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  logic      ev_pre_short,
  input  logic      ev_low_long,
  input  logic      ev_busy,
  output logic      flag,
  output err_kind_e kind
);
  err_kind_e ev_kind;
  logic      ev_any;

  always_comb begin
    ev_kind = ERR_NONE;
    if (ev_busy) begin
      ev_kind = ERR_CYC_BUSY;
    end else if (ev_low_long) begin
      ev_kind = ERR_LOW_LONG;
    end else if (ev_pre_short) begin
      ev_kind = ERR_PRE_SHORT;
    end
  end

  assign ev_any = ev_busy | ev_low_long | ev_pre_short;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      kind <= ERR_NONE;
    end else if (clear) begin
      flag <= 1'b0;
      kind <= ERR_NONE;
    end else if (!flag && ev_any) begin
      flag <= 1'b1;
      kind <= ev_kind;
    end
  end

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clear) |=> flag);

  assert_first_kind_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clear) |=> $stable(kind));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!flag && kind == ERR_NONE));
endmodule

// File: rtl/ce_latched_mem.sv
`timescale 1ns/1ps
module ce_latched_mem
  import celm_pkg::*;
#(
  parameter int ADDR_W        = 10,
  parameter int DATA_W        = 8,
  parameter int ACCESS_CYC    = 7,
  parameter int PRECHARGE_CYC = 7,
  parameter int LOW_MAX_CYC   = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              wr_strobe_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_drive,
  input  logic              err_clear,
  output logic              err_sticky,
  output logic [1:0]        err_kind
);
  logic              fall_seen, pre_done, cyc_busy, acc_ready, low_over;
  logic              accept, reject_busy, reject_pre;
  logic              sess_active, wr_start, wr_pend, we_q;
  logic              strobe_rise, commit;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] wr_data, out_data, rd_q;
  err_kind_e         kind_q;

  celm_timer #(
    .ACCESS_CYC   (ACCESS_CYC),
    .PRECHARGE_CYC(PRECHARGE_CYC),
    .LOW_MAX_CYC  (LOW_MAX_CYC)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (chip_sel_n),
    .accept     (accept),
    .sess_active(sess_active),
    .fall_seen  (fall_seen),
    .pre_done   (pre_done),
    .cyc_busy   (cyc_busy),
    .acc_ready  (acc_ready),
    .low_over   (low_over)
  );

  celm_store #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_store (
    .clk    (clk),
    .wr_en  (commit),
    .wr_addr(lat_addr),
    .wr_data(wr_data),
    .rd_addr(addr_in),
    .rd_q   (rd_q)
  );

  celm_errlog u_err (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (err_clear),
    .ev_pre_short(reject_pre),
    .ev_low_long (low_over),
    .ev_busy     (reject_busy),
    .flag        (err_sticky),
    .kind        (kind_q)
  );

  assign err_kind = kind_q;

  // admission of a new access
  assign accept      = fall_seen & pre_done & ~cyc_busy;
  assign reject_busy = fall_seen & cyc_busy;
  assign reject_pre  = fall_seen & ~cyc_busy & ~pre_done;

  // write ends on the first rising strobe or select
  assign strobe_rise = ~we_q & wr_strobe_n;
  assign commit      = sess_active & wr_pend & (chip_sel_n | strobe_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
    end else begin
      we_q <= wr_strobe_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_active <= 1'b0;
      wr_start    <= 1'b0;
      wr_pend     <= 1'b0;
      lat_addr    <= '0;
      wr_data     <= '0;
      out_data    <= '0;
    end else if (accept) begin
      sess_active <= 1'b1;
      lat_addr    <= addr_in;
      wr_start    <= ~wr_strobe_n;
      wr_pend     <= ~wr_strobe_n;
      wr_data     <= bus_in;
      out_data    <= rd_q;
    end else if (sess_active) begin
      if (chip_sel_n) begin
        sess_active <= 1'b0;
        wr_start    <= 1'b0;
        wr_pend     <= 1'b0;
      end else if (!wr_strobe_n) begin
        wr_pend <= 1'b1;
        wr_data <= bus_in;
      end else if (commit) begin
        wr_pend <= 1'b0;
      end
      if (commit) begin
        out_data <= wr_data;
      end
    end
  end

  assign bus_drive = sess_active & ~chip_sel_n & ~out_en_n & ~wr_start &
                     ~wr_pend & wr_strobe_n & acc_ready;
  assign bus_out   = bus_drive ? out_data : '0;

  assert_addr_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_active && !accept) |=> $stable(lat_addr));

  assert_cs_write_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_active && wr_start) |-> !bus_drive);

  assert_strobe_low_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_active && !chip_sel_n && !wr_strobe_n) |-> !bus_drive);

  assert_drive_after_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> acc_ready);

  assert_hiz_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel_n || out_en_n) |-> !bus_drive);

  assert_reject_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reject_pre || reject_busy) |=> !commit);
endmodule

// File: tb/test_ce_latched_mem.sv
`timescale 1ns/1ps
module test_ce_latched_mem;
  localparam int AW   = 10;
  localparam int DW   = 8;
  localparam int ACC  = 7;
  localparam int PRE  = 7;
  localparam int LMAX = 200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chip_sel_n = 1'b1, wr_strobe_n = 1'b1, out_en_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out;
  logic          bus_drive;
  logic          err_clear = 1'b0;
  logic          err_sticky;
  logic [1:0]    err_kind;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;
  logic [DW-1:0] model [1 << AW];
  bit            known [1 << AW];

  always #5 clk = ~clk;

  ce_latched_mem #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_CYC(ACC),
                   .PRECHARGE_CYC(PRE), .LOW_MAX_CYC(LMAX)) i_ce_latched_mem (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .wr_strobe_n(wr_strobe_n),
    .out_en_n(out_en_n), .addr_in(addr_in), .bus_in(bus_in), .bus_out(bus_out),
    .bus_drive(bus_drive), .err_clear(err_clear), .err_sticky(err_sticky),
    .err_kind(err_kind));

  function automatic bit exp_drive(int edges);
    return edges >= ACC;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(int n);
    chip_sel_n = 1'b1;
    wr_strobe_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic op_read(logic [AW-1:0] a, int low, bit toggle_oe, string req);
    addr_in = a; wr_strobe_n = 1'b1; out_en_n = 1'b0; chip_sel_n = 1'b0;
    for (int k = 1; k <= low; k++) begin
      @(negedge clk);
      chk({req, " drive timing R4"}, 32'(bus_drive), 32'(exp_drive(k)));
      if (k == 1) addr_in = a ^ AW'(10'h155);
      if (exp_drive(k) && known[a]) chk({req, " data R1"}, 32'(bus_out), 32'(model[a]));
      if (toggle_oe && k == ACC + 1) begin
        out_en_n = 1'b1;
        #1 chk("oe high hiz R5", 32'(bus_drive), 32'd0);
        out_en_n = 1'b0;
        #1 chk("oe low redrive R4", 32'(bus_drive), 32'd1);
      end
    end
    chip_sel_n = 1'b1;
    #1 chk("select high hiz R5", 32'(bus_drive), 32'd0);
    idle(PRE);
  endtask

  task automatic op_wr_cs(logic [AW-1:0] a, logic [DW-1:0] d, int low);
    addr_in = a; bus_in = d; wr_strobe_n = 1'b0; out_en_n = 1'b0; chip_sel_n = 1'b0;
    for (int k = 1; k <= low; k++) begin
      @(negedge clk);
      chk("select write no drive R2", 32'(bus_drive), 32'd0);
      if (k == 1) addr_in = ~a;
    end
    chip_sel_n = 1'b1;
    @(negedge clk);
    wr_strobe_n = 1'b1;
    bus_in = DW'($urandom);
    model[a] = d; known[a] = 1'b1;
    idle(PRE - 1);
  endtask

  task automatic op_wr_we(logic [AW-1:0] a, logic [DW-1:0] d, int hold);
    addr_in = a; wr_strobe_n = 1'b1; out_en_n = 1'b0; chip_sel_n = 1'b0;
    repeat (ACC) @(negedge clk);
    chk("strobe write starts as read R3", 32'(bus_drive), 32'd1);
    addr_in = AW'($urandom);
    wr_strobe_n = 1'b0; bus_in = d;
    #1 chk("strobe low hiz R3", 32'(bus_drive), 32'd0);
    for (int k = 1; k <= hold; k++) begin
      @(negedge clk);
      chk("strobe held low hiz R3", 32'(bus_drive), 32'd0);
    end
    wr_strobe_n = 1'b1; bus_in = ~d;
    @(negedge clk);
    chk("after strobe commit drive R3", 32'(bus_drive), 32'd1);
    chk("after strobe commit data R3", 32'(bus_out), 32'(d));
    model[a] = d; known[a] = 1'b1;
    idle(PRE);
  endtask

  task automatic clear_err();
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    chk("clear drops flag R9", 32'(err_sticky), 32'd0);
  endtask

  // rejected write attempt after a one-clock select pulse and a short gap
  task automatic busy_attempt(logic [AW-1:0] a);
    chip_sel_n = 1'b0; wr_strobe_n = 1'b1; out_en_n = 1'b0; addr_in = a;
    @(negedge clk);
    chip_sel_n = 1'b1;
    repeat (2) @(negedge clk);
    wr_strobe_n = 1'b0; bus_in = ~model[a]; chip_sel_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("rejected access no drive R6", 32'(bus_drive), 32'd0);
    chip_sel_n = 1'b1;
    @(negedge clk);
    wr_strobe_n = 1'b1;
    idle(PRE);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < (1 << AW); i++) begin
      known[i] = 1'b0;
      model[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset drive R10", 32'(bus_drive), 32'd0);
    chk("reset bus R10", 32'(bus_out), 32'd0);
    chk("reset flag R10", 32'(err_sticky), 32'd0);
    chk("reset kind R10", 32'(err_kind), 32'd0);

    // first access right after reset, no precharge wait (R10)
    op_wr_we(10'h012, 8'h3c, 2);
    chk("no error after first access R10", 32'(err_sticky), 32'd0);
    op_read(10'h012, ACC + 2, 1'b1, "readback");
    op_wr_cs(10'h3ff, 8'ha5, 1);
    op_read(10'h3ff, ACC, 1'b0, "edge address");
    op_wr_cs(10'h000, 8'h5a, ACC + 3);
    op_read(10'h000, ACC + 1, 1'b0, "zero address");

    // random mix with legal timing
    for (int n = 0; n < 150; n++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int sel;
      a   = AW'($urandom_range(0, 63));
      d   = DW'($urandom);
      sel = int'($urandom_range(0, 2));
      if (sel == 0) op_read(a, ACC + int'($urandom_range(0, 4)), 1'b0, "random read");
      else if (sel == 1) op_wr_cs(a, d, int'($urandom_range(1, 5)));
      else op_wr_we(a, d, int'($urandom_range(1, 3)));
    end
    chk("legal traffic no error R7", 32'(err_sticky), 32'd0);

    // access still running: busy rejection (R6)
    op_wr_cs(10'h021, 8'h77, 2);
    busy_attempt(10'h021);
    chk("busy flag R6", 32'(err_sticky), 32'd1);
    chk("busy code R6", 32'(err_kind), 32'd3);
    op_read(10'h021, ACC, 1'b0, "busy array unchanged R6");
    clear_err();

    // short precharge rejection (R7)
    op_read(10'h021, ACC + 1, 1'b0, "pre setup");
    chip_sel_n = 1'b0; wr_strobe_n = 1'b1; out_en_n = 1'b0; addr_in = 10'h021;
    repeat (ACC + 1) @(negedge clk);
    chip_sel_n = 1'b1;
    repeat (3) @(negedge clk);
    wr_strobe_n = 1'b0; bus_in = 8'hee; chip_sel_n = 1'b0;
    repeat (3) @(negedge clk);
    chip_sel_n = 1'b1;
    @(negedge clk);
    wr_strobe_n = 1'b1;
    idle(PRE);
    chk("short precharge flag R7", 32'(err_sticky), 32'd1);
    chk("short precharge code R7", 32'(err_kind), 32'd1);
    op_read(10'h021, ACC, 1'b0, "pre array unchanged R7");
    clear_err();

    // select-low limit boundary (R8)
    op_read(10'h021, LMAX, 1'b0, "limit exact");
    chk("exact limit no error R8", 32'(err_sticky), 32'd0);
    op_read(10'h021, LMAX + 1, 1'b0, "limit over");
    chk("over limit flag R8", 32'(err_sticky), 32'd1);
    chk("over limit code R8", 32'(err_kind), 32'd2);
    busy_attempt(10'h021);
    chk("first code kept R9", 32'(err_kind), 32'd2);
    chk("flag still set R9", 32'(err_sticky), 32'd1);
    clear_err();
    chk("clear drops code R9", 32'(err_kind), 32'd0);
    err_clear = 1'b1;
    op_read(10'h021, LMAX + 1, 1'b0, "clear held");
    chk("clear wins over event R9", 32'(err_sticky), 32'd0);
    err_clear = 1'b0;
    @(negedge clk);
    chk("no late flag R9", 32'(err_sticky), 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(190000 * 10);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule